// File: doc/BRIEF.md
# SPI Master with Cascaded Clock Prescalers

This block is a synchronous serial master. It moves one 8-bit or 16-bit word at a time, full-duplex, over a clock line, a data-out line and a data-in line. The serial clock comes from the system clock through two dividers in series. A coarse stage divides by 1, 4, 16 or 64. A fine stage divides by 1 to 8. The idle level of the serial clock and the edge on which output data changes can each be selected, which gives four clock formats.

There is a single-entry transmit buffer and a single-entry receive buffer. Writing a word into an empty transmit buffer starts a transfer as soon as the shifter is free and the enable is high. Each received word is placed in the receive buffer once its last bit has been sampled. If the receive buffer still holds an unread word at that point, the new word is dropped and a sticky overflow flag is set. The format, the word size and the divide ratio are taken at the start of each word, so they can be changed for the next word while the current one is still shifting.

Top module: `spi_dual_prescale_master`

## Requirements
- R1: After reset: busy_o, tx_full_o, rx_valid_o and rx_ovf_o are 0, rx_data_o is 0, sdo_o is 0 and sck_o equals cpol_i.
- R2: Each bit lasts N system clocks, where N = P*S. P is 1, 4, 16 or 64 for pri_sel_i = 0, 1, 2 or 3, and S = sec_sel_i + 1. A product of 1 runs as N = 2.
- R3: While idle, sck_o equals cpol_i. Let H = floor(N/2). With chg_idle_i = 0, the clock is at its active level (not cpol_i) for the first H cycles of each bit and idle for the rest. With chg_idle_i = 1, it is idle for the first H cycles and active for the rest.
- R4: With wide_i = 0 a word gives exactly 8 clock pulses and uses tx_data_i[7:0]. With wide_i = 1 it gives exactly 16 pulses and uses tx_data_i[15:0].
- R5: Data goes out most-significant bit first. Each bit stays on sdo_o for its whole bit period, and sdo_o is 0 when idle.
- R6: sdi_i is sampled at the clock edge that ends cycle H of each bit. The received word is assembled MSB first, and an 8-bit word is zero-extended on rx_data_o.
- R7: tx_wr_i is accepted only while tx_full_o is 0 and is ignored while it is 1. A loaded word starts on the next edge if the shifter is idle, or right after the last bit of the current word with no gap. Starting a word clears tx_full_o. busy_o is 1 for exactly the bit periods of the words.
- R8: While en_i is 0, no new word starts. A loaded word waits in the transmit buffer.
- R9: A received word appears on rx_data_o, with rx_valid_o set, on the edge that ends its last bit. rx_rd_i clears rx_valid_o. A read on that same edge frees the buffer for the new word.
- R10: If rx_valid_o is 1 and no read occurs when a word completes, the word is discarded, rx_data_o is unchanged and rx_ovf_o is set. ovf_clr_i clears the flag, and a new overflow on the same edge takes priority over the clear.
- R11: Word size, edge select and divide ratio are captured when a word starts. Changing them during the word has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Allows new words to start |
| cpol_i | input | 1 | Serial clock idle level |
| chg_idle_i | input | 1 | 1: data changes on the active-to-idle clock transition |
| wide_i | input | 1 | 1: 16-bit words, 0: 8-bit words |
| pri_sel_i | input | 2 | Coarse divider select (1, 4, 16, 64) |
| sec_sel_i | input | 3 | Fine divider, divide by value + 1 |
| tx_data_i | input | 16 | Word to transmit |
| tx_wr_i | input | 1 | Load tx_data_i into the transmit buffer |
| tx_full_o | output | 1 | Transmit buffer is occupied |
| rx_data_o | output | 16 | Receive buffer contents |
| rx_valid_o | output | 1 | Receive buffer holds an unread word |
| rx_rd_i | input | 1 | Marks the receive buffer as read |
| rx_ovf_o | output | 1 | Sticky receive overflow flag |
| ovf_clr_i | input | 1 | Clears rx_ovf_o |
| busy_o | output | 1 | A word is being shifted |
| sck_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
A divide counter that is off by one shows up on sck_o within the first bit period. It also shifts every later edge and lengthens busy_o by a multiple of the word size. A bit counter or size latch that is wrong changes the pulse count and the moment rx_valid_o rises, which can be seen at the end of the first word. A sampling point that is wrong shows only in rx_data_o, one word later. The receive data line is therefore driven with random values every cycle, so that a sample taken one cycle early or late gives the wrong word. The buffer-state errors are different: a dropped full flag, a lost overflow or an overwritten receive word stays hidden until two words complete with no read in between.

// File: rtl/spi_mst_pkg.sv
`timescale 1ns/1ps
package spi_mst_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned NARROW_W  = 8;
  localparam int unsigned PRI_W     = 2;
  localparam int unsigned SEC_W     = 3;
  localparam int unsigned PER_W     = 10;
  localparam int unsigned BIT_CNT_W = $clog2(WORD_W);

  // bit period in system clocks; 1 is not representable as two phases
  function automatic logic [PER_W-1:0] calc_period(input logic [PRI_W-1:0] pri,
                                                   input logic [SEC_W-1:0] sec);
    logic [PER_W-1:0] coarse;
    logic [PER_W-1:0] prod;
    coarse = PER_W'(1) << {pri, 1'b0};
    prod   = PER_W'(coarse * (PER_W'(sec) + PER_W'(1)));
    if (prod < PER_W'(2)) prod = PER_W'(2);
    return prod;
  endfunction
endpackage

// File: rtl/spi_baud_gen.sv
`timescale 1ns/1ps
module spi_baud_gen #(
  parameter int unsigned PER_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PER_W-1:0] period_i,
  output logic             mid_o,
  output logic             end_o,
  output logic             late_o
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] half;

  assign half   = period_i >> 1;
  assign end_o  = run_i && (cnt_q == period_i - PER_W'(1));
  assign mid_o  = run_i && (cnt_q == half);
  assign late_o = cnt_q >= half;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || end_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + PER_W'(1);
  end
endmodule

// File: rtl/spi_word_shifter.sv
`timescale 1ns/1ps
module spi_word_shifter #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NARROW_W  = 8,
  parameter int unsigned BIT_CNT_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              wide_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic              mid_i,
  input  logic              end_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              last_o,
  output logic [WORD_W-1:0] rx_word_o
);
  localparam int unsigned PAD_W = WORD_W - NARROW_W;

  logic [WORD_W-1:0]    sh_q;
  logic [BIT_CNT_W-1:0] bit_q;
  logic                 samp_q;
  logic                 wide_q;
  logic                 in_bit;
  logic [WORD_W-1:0]    shifted;

  // when the period is 2 the sample point and the bit boundary coincide
  assign in_bit  = mid_i ? sdi_i : samp_q;
  assign shifted = {sh_q[WORD_W-2:0], in_bit};
  assign sdo_o   = sh_q[WORD_W-1];
  assign last_o  = end_i && (bit_q == (wide_q ? BIT_CNT_W'(WORD_W-1) : BIT_CNT_W'(NARROW_W-1)));
  assign rx_word_o = wide_q ? shifted : {{PAD_W{1'b0}}, shifted[NARROW_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bit_q  <= '0;
      samp_q <= 1'b0;
      wide_q <= 1'b0;
    end else begin
      if (mid_i) samp_q <= sdi_i;
      if (load_i) begin
        sh_q   <= wide_i ? load_data_i : {load_data_i[NARROW_W-1:0], {PAD_W{1'b0}}};
        bit_q  <= '0;
        wide_q <= wide_i;
      end else if (end_i) begin
        sh_q  <= shifted;
        bit_q <= bit_q + BIT_CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/spi_dual_prescale_master.sv
`timescale 1ns/1ps
module spi_dual_prescale_master
  import spi_mst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpol_i,
  input  logic              chg_idle_i,
  input  logic              wide_i,
  input  logic [PRI_W-1:0]  pri_sel_i,
  input  logic [SEC_W-1:0]  sec_sel_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_wr_i,
  output logic              tx_full_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_rd_i,
  output logic              rx_ovf_o,
  input  logic              ovf_clr_i,
  output logic              busy_o,
  output logic              sck_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  logic              busy_q, txf_q, rxv_q, ovf_q, chg_q;
  logic [WORD_W-1:0] txb_q, rxb_q;
  logic [PER_W-1:0]  per_q;
  logic              mid, bend, late, last, sh_sdo, start, rx_free;
  logic [WORD_W-1:0] rx_word;

  assign start   = en_i && txf_q && (!busy_q || last);
  assign rx_free = !rxv_q || rx_rd_i;

  spi_baud_gen #(.PER_W(PER_W)) u_baud (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (busy_q),
    .period_i (per_q),
    .mid_o    (mid),
    .end_o    (bend),
    .late_o   (late)
  );

  spi_word_shifter #(
    .WORD_W    (WORD_W),
    .NARROW_W  (NARROW_W),
    .BIT_CNT_W (BIT_CNT_W)
  ) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start),
    .wide_i      (wide_i),
    .load_data_i (txb_q),
    .mid_i       (mid),
    .end_i       (bend),
    .sdi_i       (sdi_i),
    .sdo_o       (sh_sdo),
    .last_o      (last),
    .rx_word_o   (rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      txf_q  <= 1'b0;
      rxv_q  <= 1'b0;
      ovf_q  <= 1'b0;
      chg_q  <= 1'b0;
      txb_q  <= '0;
      rxb_q  <= '0;
      per_q  <= '0;
    end else begin
      if (start) begin
        busy_q <= 1'b1;
        per_q  <= calc_period(pri_sel_i, sec_sel_i);
        chg_q  <= chg_idle_i;
      end else if (last) begin
        busy_q <= 1'b0;
      end
      if (tx_wr_i && !txf_q) begin
        txf_q <= 1'b1;
        txb_q <= tx_data_i;
      end else if (start) begin
        txf_q <= 1'b0;
      end
      if (last && rx_free) begin
        rxb_q <= rx_word;
        rxv_q <= 1'b1;
      end else if (rx_rd_i) begin
        rxv_q <= 1'b0;
      end
      if (last && !rx_free) ovf_q <= 1'b1;
      else if (ovf_clr_i)   ovf_q <= 1'b0;
    end
  end

  assign sck_o      = cpol_i ^ (busy_q && (chg_q ? late : !late));
  assign sdo_o      = busy_q && sh_sdo;
  assign busy_o     = busy_q;
  assign tx_full_o  = txf_q;
  assign rx_data_o  = rxb_q;
  assign rx_valid_o = rxv_q;
  assign rx_ovf_o   = ovf_q;
endmodule

// File: rtl/spi_mst_checker.sv
`timescale 1ns/1ps
module spi_mst_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic        cpol_i,
  input logic        tx_full_o,
  input logic [15:0] rx_data_o,
  input logic        rx_valid_o,
  input logic        rx_rd_i,
  input logic        rx_ovf_o,
  input logic        busy_o,
  input logic        sck_o,
  input logic        sdo_o
);
  AST_SCK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sck_o == cpol_i)); // R3
  AST_SDO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sdo_o); // R5
  AST_TX_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full_o && !busy_o && en_i) |=> !tx_full_o); // R7
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !busy_o) |=> !busy_o); // R8
  AST_RX_AFTER_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_valid_o) |-> $past(busy_o)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_rd_i) |=> $stable(rx_data_o)); // R10
  AST_OVF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_ovf_o) |-> ($past(rx_valid_o) && rx_valid_o)); // R10
endmodule

bind spi_dual_prescale_master spi_mst_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .cpol_i     (cpol_i),
  .tx_full_o  (tx_full_o),
  .rx_data_o  (rx_data_o),
  .rx_valid_o (rx_valid_o),
  .rx_rd_i    (rx_rd_i),
  .rx_ovf_o   (rx_ovf_o),
  .busy_o     (busy_o),
  .sck_o      (sck_o),
  .sdo_o      (sdo_o)
);

// File: tb/spi_dual_prescale_master_tb.sv
`timescale 1ns/1ps
module spi_dual_prescale_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1, cpol = 1'b0, chg = 1'b0, wide = 1'b0;
  logic [1:0]  pri = 2'd0;
  logic [2:0]  sec = 3'd2;
  logic [15:0] tx_data = '0;
  logic        tx_wr = 1'b0, rx_rd = 1'b0, ovf_clr = 1'b0, sdi = 1'b0;
  logic        tx_full, rx_valid, rx_ovf, busy, sck, sdo;
  logic [15:0] rx_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_dual_prescale_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cpol_i(cpol), .chg_idle_i(chg),
    .wide_i(wide), .pri_sel_i(pri), .sec_sel_i(sec), .tx_data_i(tx_data),
    .tx_wr_i(tx_wr), .tx_full_o(tx_full), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .rx_rd_i(rx_rd), .rx_ovf_o(rx_ovf), .ovf_clr_i(ovf_clr), .busy_o(busy),
    .sck_o(sck), .sdo_o(sdo), .sdi_i(sdi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // behavioural reference: ints and bit arithmetic only
  int m_busy, m_full, m_rxv, m_ovf, m_cnt, m_bits, m_w, m_per, m_edge;
  int m_buf, m_word, m_rx, m_acc;
  int fin, rfree, wfull;

  function automatic int bit_period(input int p, input int s);
    int v;
    v = (1 << (2 * p)) * (s + 1);
    return (v < 2) ? 2 : v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_full = 0; m_rxv = 0; m_ovf = 0; m_cnt = 0; m_bits = 0;
      m_w = 8; m_per = 2; m_edge = 0; m_buf = 0; m_word = 0; m_rx = 0; m_acc = 0;
    end else begin
      fin = 0;
      if (m_busy != 0) begin
        if (m_cnt == m_per / 2) m_acc = (m_acc << 1) | int'(sdi);
        if (m_cnt == m_per - 1) begin
          m_cnt = 0;
          if (m_bits == m_w - 1) fin = 1; else m_bits++;
        end else m_cnt++;
      end
      rfree = (m_rxv == 0 || rx_rd) ? 1 : 0;
      wfull = m_full;
      if (fin != 0) begin
        m_busy = 0;
        if (rfree != 0) begin m_rx = m_acc & ((1 << m_w) - 1); m_rxv = 1; end
        else m_ovf = 1;
      end
      if (!(fin != 0 && rfree != 0) && rx_rd) m_rxv = 0;
      if (!(fin != 0 && rfree == 0) && ovf_clr) m_ovf = 0;
      if (en && wfull != 0 && m_busy == 0) begin
        m_busy = 1; m_cnt = 0; m_bits = 0; m_acc = 0; m_word = m_buf;
        m_w = wide ? 16 : 8; m_per = bit_period(int'(pri), int'(sec)); m_edge = int'(chg);
        m_full = 0;
      end
      if (tx_wr && wfull == 0) begin m_buf = int'(tx_data); m_full = 1; end
    end
  end

  // per-cycle comparison plus pulse/period monitor, away from the active edge
  int pulses = 0, last_lead = -1, gap = -1;
  bit act_prev = 0;
  always begin
    @(negedge clk);
    #1;
    cyc++;
    if (rst_n && !done) begin
      logic exp_act;
      exp_act = (m_busy != 0) && ((m_edge != 0) ? (m_cnt >= m_per / 2) : (m_cnt < m_per / 2));
      chk("R3 sck", 32'(sck), 32'(cpol ^ exp_act));
      chk("R5 sdo", 32'(sdo), (m_busy != 0) ? 32'((m_word >> (m_w - 1 - m_bits)) & 1) : 32'd0);
      chk("R7 busy", 32'(busy), 32'(m_busy));
      chk("R7 tx_full", 32'(tx_full), 32'(m_full));
      chk("R9 rx_valid", 32'(rx_valid), 32'(m_rxv));
      chk("R6 rx_data", 32'(rx_data), 32'(m_rx));
      chk("R10 ovf", 32'(rx_ovf), 32'(m_ovf));
      if (busy && (sck != cpol) && !act_prev) begin
        pulses++;
        if (last_lead >= 0) gap = cyc - last_lead;
        last_lead = cyc;
      end
      act_prev = busy && (sck != cpol);
    end
  end

  // random data on the input line every cycle
  always @(negedge clk) sdi <= 1'($urandom);

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      finish_up();
    end
  end

  task automatic send(input logic [15:0] d);
    @(negedge clk); tx_data = d; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic send_measure(input logic [15:0] d, input int exp_n, input int exp_gap,
                              input string ptag, input string gtag);
    pulses = 0; last_lead = -1; gap = -1;
    send(d);
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    #2;
    chk(ptag, 32'(pulses), 32'(exp_n));
    chk(gtag, 32'(gap), 32'(exp_gap));
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  initial begin
    // R1: reset state, idle clock follows cpol
    repeat (3) @(negedge clk);
    #1;
    chk("R1 busy", 32'(busy), 0); chk("R1 tx_full", 32'(tx_full), 0);
    chk("R1 rx_valid", 32'(rx_valid), 0); chk("R1 ovf", 32'(rx_ovf), 0);
    chk("R1 rx_data", 32'(rx_data), 0); chk("R1 sdo", 32'(sdo), 0);
    chk("R1 sck low", 32'(sck), 0);
    cpol = 1'b1; #1;
    chk("R1 sck high", 32'(sck), 1);
    cpol = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3, R4: all four formats, both sizes, N = 3
    for (int m = 0; m < 8; m++) begin
      cpol = m[0]; chg = m[1]; wide = m[2];
      send_measure(16'hA5C3 ^ 16'(m * 16'h1111), wide ? 16 : 8, 3, "R4 pulses", "R3 period");
    end

    // R2: divider sweep, including the clamped product and the slowest setting
    cpol = 1'b0; chg = 1'b1; wide = 1'b0;
    pri = 2'd1; sec = 3'd1; send_measure(16'h0081, 8, 8,   "R4 pulses", "R2 period 4x2");
    pri = 2'd2; sec = 3'd0; send_measure(16'h00F0, 8, 16,  "R4 pulses", "R2 period 16x1");
    pri = 2'd0; sec = 3'd0; send_measure(16'h003C, 8, 2,   "R4 pulses", "R2 period clamp");
    pri = 2'd0; sec = 3'd1; send_measure(16'h0055, 8, 2,   "R4 pulses", "R2 period 1x2");
    pri = 2'd3; sec = 3'd7; send_measure(16'h00AA, 8, 512, "R4 pulses", "R2 period 64x8");
    pri = 2'd0; sec = 3'd2;

    // R11: config changed during an 8-bit word does not affect it
    pulses = 0; last_lead = -1; gap = -1;
    send(16'h1234);
    while (!busy) @(negedge clk);
    wide = 1'b1; pri = 2'd1; chg = 1'b0;
    while (busy) @(negedge clk);
    #2;
    chk("R11 pulses", 32'(pulses), 8);
    chk("R11 period", 32'(gap), 3);
    wide = 1'b0; pri = 2'd0; chg = 1'b1;

    // R7, R10: back-to-back words, write while full, overflow with no read
    send(16'h00C1);
    while (!busy) @(negedge clk);
    send(16'h00C2);
    #1 chk("R7 full while busy", 32'(tx_full), 1);
    send(16'h00C3);
    while (!(busy && !tx_full)) @(negedge clk);
    while (busy) @(negedge clk);
    #2;
    chk("R10 ovf set", 32'(rx_ovf), 1);
    chk("R7 third write dropped", 32'(tx_full), 0);
    @(negedge clk); ovf_clr = 1'b1; rx_rd = 1'b1;
    @(negedge clk); ovf_clr = 1'b0; rx_rd = 1'b0;
    #1 chk("R10 ovf cleared", 32'(rx_ovf), 0);

    // R8: enable low holds a loaded word
    en = 1'b0;
    send(16'h005A);
    repeat (20) @(negedge clk);
    #1 chk("R8 no start", 32'(busy), 0);
    chk("R8 word held", 32'(tx_full), 1);
    en = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk("R8 start after enable", 32'(busy), 1);
    while (busy) @(negedge clk);

    // random traffic: same-cycle reads, overflow races, config churn
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      tx_wr   = ($urandom % 4) == 0;
      tx_data = 16'($urandom);
      rx_rd   = ($urandom % 6) == 0;
      ovf_clr = ($urandom % 10) == 0;
      en      = ($urandom % 8) != 0;
      chg     = 1'($urandom);
      wide    = 1'($urandom);
      pri     = 2'($urandom % 2);
      sec     = 3'($urandom);
      if (($urandom % 50) == 0) cpol = ~cpol;
    end
    @(negedge clk);
    tx_wr = 1'b0; rx_rd = 1'b0; ovf_clr = 1'b0; en = 1'b1;
    repeat (600) @(negedge clk);
    #2;
    finish_up();
  end
endmodule